// File: doc/BRIEF.md
# Radix-2 Booth Sequential Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit signed product. It works one multiplier bit per clock. A working register holds an upper accumulator, a lower half that starts out holding the multiplier, and one history bit to the right of it. In each iteration the block looks at the lowest multiplier bit together with the history bit. From that pair it adds the multiplicand to the upper accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole register right by one place and copies the sign bit into the vacated top position. A single adder does both the add and the subtract: for a subtract it inverts the multiplicand and forces the carry-in to one.

The upper accumulator carries one guard bit above its N visible bits. With this bit, subtracting the most negative multiplicand cannot overflow the accumulator, so every pair of operands produces a correct product.

A client pulses `start_i` while the block is idle. The operands are captured on that edge. After N iterations `done_o` is high for one cycle and `product_o` holds the result. The result stays on `product_o` until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `product_o` are all zero until the first start is accepted.
- R2: A start is accepted when `start_i` is high at a rising edge while `busy_o` is low. `busy_o` is high in the cycle after an accepted start.
- R3: `busy_o` stays high for exactly N cycles after an accepted start. In the following cycle `busy_o` is low and `done_o` is high, and `done_o` is high for only that one cycle.
- R4: When `done_o` is high, `product_o` equals the signed two's-complement product of the multiplicand and the multiplier. Both operands are N-bit two's-complement values, and the product is a 2N-bit two's-complement value.
- R5: `mcand_i` and `mplier_i` are sampled only on the accepted start edge. Changes to them while busy do not change the result.
- R6: `start_i` asserted while `busy_o` is high is ignored. The running operation finishes at its original time with its original operands.
- R7: After `done_o`, `product_o` keeps the result unchanged until the next accepted start.
- R8: The most negative value times the most negative value gives the exact positive product 2^(2N-2). Also, the most negative value times the most positive value gives a correct result in both operand orders.
- R9: A zero multiplier gives a zero product. A multiplier of all ones (-1) gives the multiplicand negated and sign-extended to 2N bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication; accepted only while idle |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Signed product; held after `done_o` until the next start |

## Verification
A wrong recoding decision, a shift that drops the sign, or a lost guard bit shows up as a wrong `product_o` on the `done_o` cycle. This happens N cycles after the start that triggered it. The directed operands are chosen to expose these errors: long runs of ones, alternating bits, extreme negative values and -1. A counter that is off by one shows up as `done_o` arriving one cycle early or late compared with the start edge. An operand register that reloads while busy shows up as a product that matches the disturbed inputs rather than the captured ones.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    BOOTH_NOP = 2'd0,
    BOOTH_ADD = 2'd1,
    BOOTH_SUB = 2'd2
  } booth_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);

  // 10: run of ones begins -> subtract; 01: run ends -> add
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b10:   op_o = BOOTH_SUB;
      2'b01:   op_o = BOOTH_ADD;
      default: op_o = BOOTH_NOP;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  booth_op_e    op_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  always_comb begin
    unique case (op_i)
      BOOTH_ADD: b_eff = b_i;
      BOOTH_SUB: b_eff = ~b_i;
      default:   b_eff = '0;
    endcase
  end

  assign carry[0] = (op_i == BOOTH_SUB);

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_mul_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  booth_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last;

  assign last   = (cnt_q == LAST);
  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);

  localparam int unsigned HW = N + 1;  // upper half plus guard bit

  logic          load, step;
  logic [HW-1:0] hi_q;
  logic [N-1:0]  lo_q;
  logic          hist_q;
  logic [N-1:0]  mcand_q;
  logic [HW-1:0] mcand_ext;
  logic [HW-1:0] sum;
  booth_op_e     op;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_recoder u_rec (
    .cur_i (lo_q[0]),
    .prev_i(hist_q),
    .op_o  (op)
  );

  assign mcand_ext = {mcand_q[N-1], mcand_q};

  booth_addsub #(.W(HW)) u_alu (
    .a_i  (hi_q),
    .b_i  (mcand_ext),
    .op_i (op),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      hist_q  <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      hi_q    <= '0;
      lo_q    <= mplier_i;
      hist_q  <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step) begin
      // arithmetic shift of {sum, lo, hist}; sign from updated upper half
      hi_q   <= {sum[HW-1], sum[HW-1:1]};
      lo_q   <= {sum[0], lo_q[N-1:1]};
      hist_q <= lo_q[0];
    end
  end

  assign product_o = {hi_q[N-1:0], lo_q};

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplier_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*N-1:0] product_o
);

  localparam int unsigned RW = $clog2(N + 1) + 1;

  logic [N-1:0]   a_q, b_q;
  logic [RW-1:0]  run_q;
  logic [2*N-1:0] ref_prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      run_q <= '0;
    end else begin
      if (start_i && !busy_o) begin
        a_q <= mcand_i;
        b_q <= mplier_i;
      end
      run_q <= busy_o ? run_q + 1'b1 : '0;
    end
  end

  assign ref_prod = {{N{a_q[N-1]}}, a_q} * {{N{b_q[N-1]}}, b_q};

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q == RW'(N)));

  assert_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (product_o == ref_prod));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .product_o(product_o)
);

// File: tb/booth_mul_test.sv
module booth_mul_test;

  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic [N-1:0]  mcand_i, mplier_i;
  logic          busy_o, done_o;
  logic [PW-1:0] product_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  booth_mul #(.N(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  int            checks = 0;
  int            errors = 0;
  int            run    = 0;
  bit            ended  = 0;
  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] last_exp;
  logic [31:0]   rnd = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    return {{N{a[N-1]}}, a} * {{N{b[N-1]}}, b};
  endfunction

  // driver: issue one operation, push expectation
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b,
                       input string tag, input bit disturb);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    mcand_i  = a;
    mplier_i = b;
    start_i  = 1'b1;
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
    last_exp = ref_mul(a, b);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", PW'(busy_o), PW'(1));
    if (disturb) begin
      // R5/R6: new operands and a start pulse while busy
      mcand_i  = ~a;
      mplier_i = b ^ 8'h5A;
      start_i  = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
  endtask

  // monitor: scoreboard compare on done
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o) run++;
      if (done_o) begin
        check(run == N, "R3 latency", PW'(run), PW'(N));
        check(busy_o == 1'b0, "R3 idle at done", PW'(busy_o), PW'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", product_o, '0);
        end else begin
          automatic logic [PW-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(product_o == e, t, product_o, e);
        end
        run = 0;
      end else if (!busy_o) begin
        run = 0;
      end
    end
  end

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    rst_ni   = 1'b0;
    start_i  = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    last_exp = '0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && done_o == 0 && product_o == 0, "R1 reset state",
          {busy_o, done_o, product_o[PW-3:0]}, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(busy_o == 0 && done_o == 0 && product_o == 0, "R1 after release",
          {busy_o, done_o, product_o[PW-3:0]}, '0);

    issue(8'h80, 8'h80, "R8 min*min", 0);
    issue(8'h7F, 8'h80, "R8 max*min", 0);
    issue(8'h80, 8'h7F, "R8 min*max", 0);
    issue(8'h7F, 8'h7F, "R4 max*max", 0);
    issue(8'h02, 8'h06, "R4 2*6", 0);
    issue(8'h02, 8'hFD, "R4 2*-3", 0);
    issue(8'hFB, 8'h55, "R4 alternating bits", 0);
    issue(8'h33, 8'h7E, "R4 run of ones", 0);
    issue(8'h35, 8'h00, "R9 zero multiplier", 0);
    issue(8'h35, 8'hFF, "R9 times -1", 0);
    issue(8'h80, 8'hFF, "R9 min times -1", 0);
    issue(8'h13, 8'hE7, "R5 R6 disturbed inputs", 1);
    issue(8'hC4, 8'h39, "R6 start while busy", 1);

    while (exp_q.size() != 0 || busy_o) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    check(product_o == last_exp, "R7 hold after done", product_o, last_exp);
    check(done_o == 1'b0, "R3 single done pulse", PW'(done_o), PW'(0));

    for (int i = 0; i < 400; i++) begin
      rnd = rnd ^ (rnd << 13);
      rnd = rnd ^ (rnd >> 17);
      rnd = rnd ^ (rnd << 5);
      issue(rnd[7:0], rnd[15:8], "R4 random", rnd[20] & rnd[21]);
    end

    while (exp_q.size() != 0 || busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    check(product_o == last_exp, "R7 final hold", product_o, last_exp);
    finish_run();
  end

endmodule